// File: doc/BRIEF.md
# Wide Nonlinear State Round

This block holds a 544-bit state, arranged as seventeen 32-bit words, and advances it by one full round for each accepted beat. A round runs four parallel steps in a fixed order. First comes a nonlinear mix of neighbouring words. Next each word is rotated by its own amount and moved to a new position. Then a three-tap linear diffusion is applied. Last, a constant, an eight-word injection block and an eight-word buffer stage are added in by XOR. All index arithmetic wraps modulo 17.

The surrounding logic owns the 32-stage buffer and all sequencing. In push beats it supplies the external message or key block on `inj_i`. In pull beats it supplies buffer stage 4 on `inj_i`. In both cases it supplies buffer stage 16 on `stage_i`. Between beats it reads `out_o` as the output block and `fb_o` as the word fed back into the buffer. A clear beat zeroes the state.

Top module: `wide_round_top`

## Requirements
- R1: While `rst_ni` is low, every state word is zero, `out_o` and `fb_o` read zero, and `ready_o` is low.
- R2: An accepted beat with `mode_i` = 2'b00 (clear) sets all seventeen state words to zero.
- R3: The first step computes, for each word i, g_i = a_i XOR (a_{i+1} OR NOT a_{i+2}), with indices taken mod 17.
- R4: The second step computes p_i = rotl(g_j, k), where j = 7i mod 17 and k = i(i+1)/2 mod 32, and rotation moves bits from LSB toward MSB.
- R5: The third step computes t_i = p_i XOR p_{i+1} XOR p_{i+4}, with indices taken mod 17.
- R6: The final step produces new state words as follows: word 0 is t_0 XOR 32'h1; word 1+i is t_{1+i} XOR injection word i; word 9+i is t_{9+i} XOR stage word i, for i from 0 to 7. Bus word i occupies bits [32i+31:32i].
- R7: An accepted beat with `mode_i` = 2'b01 (push) or 2'b10 (pull) loads the state with the result of the four steps, applied in the order R3, R4, R5, R6.
- R8: `out_o` carries state words 9..16 and `fb_o` carries state words 1..8, packed with word 9 (or word 1) in bits [31:0]. Both are taken from the state register before the beat updates it, and they change in the cycle after the beat.
- R9: A cycle with `valid_i` low, or an accepted beat with `mode_i` = 2'b11, leaves the state unchanged.
- R10: `ready_o` goes high on the first clock edge after reset is released and stays high; a beat is accepted when `valid_i` and `ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Beat request |
| ready_o | output | 1 | Beat acceptance |
| mode_i | input | 2 | 00 clear, 01 push, 10 pull, 11 no-op |
| inj_i | input | 256 | Injection block: external input (push) or buffer stage 4 (pull) |
| stage_i | input | 256 | Buffer stage 16 words |
| out_o | output | 256 | State words 9..16 |
| fb_o | output | 256 | State words 1..8, feedback to the buffer |

## Verification
In a single cycle the block both presents the pre-round state on `out_o` and `fb_o` and commits the next round into the register. A design that forwards the freshly computed state, or that lags by one beat, would mix these two up. The bench provokes this overlap with back-to-back pull beats. Before each edge it compares both outputs against its model's pre-beat state, and after the last beat it compares against the post-round state. The model is rebuilt from the four step formulas, so any slip in a rotation amount, tap or injection position also shows up.

// File: rtl/wide_round_pkg.sv
package wide_round_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 8;
  localparam int N_WORDS   = 2 * BLK_WORDS + 1;
  localparam int BLK_W     = WORD_W * BLK_WORDS;

  typedef logic [N_WORDS-1:0][WORD_W-1:0]   state_t;
  typedef logic [BLK_WORDS-1:0][WORD_W-1:0] blk_t;

  typedef enum logic [1:0] {
    MODE_CLR  = 2'b00,
    MODE_PUSH = 2'b01,
    MODE_PULL = 2'b10,
    MODE_NOP  = 2'b11
  } mode_e;
endpackage

// File: rtl/wide_round_mix.sv
module wide_round_mix
  import wide_round_pkg::*;
(
  input  state_t a_i,
  output state_t g_o
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_w
    localparam int I1 = (i + 1) % N_WORDS;
    localparam int I2 = (i + 2) % N_WORDS;
    assign g_o[i] = a_i[i] ^ (a_i[I1] | ~a_i[I2]);
  end
endmodule

// File: rtl/wide_round_perm.sv
module wide_round_perm
  import wide_round_pkg::*;
#(
  parameter int STEP = 7
) (
  input  state_t g_i,
  output state_t p_o
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_w
    localparam int SRC = (STEP * i) % N_WORDS;
    localparam int ROT = ((i * (i + 1)) / 2) % WORD_W;
    if (ROT == 0) begin : g_plain
      assign p_o[i] = g_i[SRC];
    end else begin : g_rot
      assign p_o[i] = {g_i[SRC][WORD_W-1-ROT:0], g_i[SRC][WORD_W-1:WORD_W-ROT]};
    end
  end

  // rotation and word moves never create or destroy ones
  always_comb begin
    if (!$isunknown(g_i))
      p_popcount_r4: assert ($countones(p_o) == $countones(g_i));
  end
endmodule

// File: rtl/wide_round_diff.sv
module wide_round_diff
  import wide_round_pkg::*;
#(
  parameter int TAP_A = 1,
  parameter int TAP_B = 4
) (
  input  state_t p_i,
  output state_t t_o
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_w
    localparam int IA = (i + TAP_A) % N_WORDS;
    localparam int IB = (i + TAP_B) % N_WORDS;
    assign t_o[i] = p_i[i] ^ p_i[IA] ^ p_i[IB];
  end

  // each input word feeds three outputs, so word-wise parity is kept
  logic [WORD_W-1:0] par_in, par_out;
  always_comb begin
    par_in  = '0;
    par_out = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      par_in  = par_in ^ p_i[i];
      par_out = par_out ^ t_o[i];
    end
    if (!$isunknown(p_i))
      p_parity_r5: assert (par_in == par_out);
  end
endmodule

// File: rtl/wide_round_top.sv
module wide_round_top
  import wide_round_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  output logic                     ready_o,
  input  logic [1:0]               mode_i,
  input  logic [BLK_W-1:0]         inj_i,
  input  logic [BLK_W-1:0]         stage_i,
  output logic [BLK_W-1:0]         out_o,
  output logic [BLK_W-1:0]         fb_o
);
  localparam logic [WORD_W-1:0] ROUND_CONST = WORD_W'(1);

  state_t state_q, g_w, p_w, t_w, nxt_w;
  blk_t   inj_w, stg_w;
  logic   ready_q, fire;

  assign inj_w = inj_i;
  assign stg_w = stage_i;
  assign fire  = valid_i && ready_q;

  wide_round_mix u_mix (.a_i(state_q), .g_o(g_w));
  wide_round_perm #(.STEP(7)) u_perm (.g_i(g_w), .p_o(p_w));
  wide_round_diff #(.TAP_A(1), .TAP_B(4)) u_diff (.p_i(p_w), .t_o(t_w));

  always_comb begin
    nxt_w    = t_w;
    nxt_w[0] = t_w[0] ^ ROUND_CONST;
    for (int i = 0; i < BLK_WORDS; i++) begin
      nxt_w[1 + i]             = t_w[1 + i] ^ inj_w[i];
      nxt_w[BLK_WORDS + 1 + i] = t_w[BLK_WORDS + 1 + i] ^ stg_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (fire) begin
        case (mode_e'(mode_i))
          MODE_CLR:             state_q <= '0;
          MODE_PUSH, MODE_PULL: state_q <= nxt_w;
          default:              state_q <= state_q;
        endcase
      end
    end
  end

  assign ready_o = ready_q;
  assign out_o   = state_q[N_WORDS-1:BLK_WORDS+1];
  assign fb_o    = state_q[BLK_WORDS:1];

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mode_i == MODE_CLR) |=> (out_o == '0 && fb_o == '0));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> ($stable(out_o) && $stable(fb_o)));

  p_nop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mode_i == MODE_NOP) |=> ($stable(out_o) && $stable(fb_o)));

  p_ready_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // from an all-zero state with zero inputs, the mix step yields all ones everywhere
  p_zero_round_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (mode_i == MODE_PUSH || mode_i == MODE_PULL) && out_o == '0 && fb_o == '0
     && state_q[0] == '0 && inj_i == '0 && stage_i == '0)
    |=> (fb_o == '1 && out_o == '1));
endmodule

// File: tb/wide_round_tb.sv
module wide_round_top_tb_top;
  typedef logic [16:0][31:0] st_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         ready_o;
  logic [1:0]   mode_i = 2'b11;
  logic [255:0] inj_i = '0;
  logic [255:0] stage_i = '0;
  logic [255:0] out_o, fb_o;

  int   checks = 0;
  int   errors = 0;
  st_t  m = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk_i = ~clk_i;

  wide_round_top dut_i (.*);

  function automatic logic [31:0] rotl(input logic [31:0] x, input int k);
    return (k == 0) ? x : ((x << k) | (x >> (32 - k)));
  endfunction

  function automatic st_t model_round(input st_t a, input logic [255:0] inj,
                                      input logic [255:0] stg);
    st_t g, p, t, s;
    for (int i = 0; i < 17; i++) g[i] = a[i] ^ (a[(i+1)%17] | ~a[(i+2)%17]);
    for (int i = 0; i < 17; i++) p[i] = rotl(g[(7*i)%17], ((i*(i+1))/2) % 32);
    for (int i = 0; i < 17; i++) t[i] = p[i] ^ p[(i+1)%17] ^ p[(i+4)%17];
    s = t;
    s[0] = t[0] ^ 32'h1;
    for (int i = 0; i < 8; i++) begin
      s[1+i] = t[1+i] ^ inj[32*i +: 32];
      s[9+i] = t[9+i] ^ stg[32*i +: 32];
    end
    return s;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic rand_blk(output logic [255:0] b);
    for (int i = 0; i < 8; i++) begin
      seed = xs(seed);
      b[32*i +: 32] = seed;
    end
  endtask

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " out_o"}, out_o, m[16:9]);
    check({req, " fb_o"}, fb_o, m[8:1]);
  endtask

  // called at a negedge; leaves the bench at the following negedge
  task automatic beat(input logic [1:0] md, input logic [255:0] inj,
                      input logic [255:0] stg, input string req);
    valid_i = 1'b1; mode_i = md; inj_i = inj; stage_i = stg;
    #0 check_state({req, " R8 pre-beat"});
    @(posedge clk_i);
    if (md == 2'b00) m = '0;
    else if (md == 2'b01 || md == 2'b10) m = model_round(m, inj, stg);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R1 out_o in reset", out_o, '0);
    check("R1 fb_o in reset", fb_o, '0);
    check("R1 ready_o in reset", {255'b0, ready_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 ready_o after reset", {255'b0, ready_o}, 256'd1);
  endtask

  task automatic t_zero_round;
    beat(2'b01, '0, '0, "R3 R6 zero");
    check("R3 R6 zero-round out_o", out_o, '1);
    check("R3 R6 zero-round fb_o", fb_o, '1);
  endtask

  task automatic t_push_seq;
    logic [255:0] a, b;
    for (int n = 0; n < 24; n++) begin
      rand_blk(a); rand_blk(b);
      beat(2'b01, a, b, "R4 R5 R7 push");
    end
    check_state("R7 push result");
  endtask

  task automatic t_single_bit;
    logic [255:0] a;
    beat(2'b00, '0, '0, "R2 pre");
    for (int w = 0; w < 8; w++) begin
      a = '0; a[32*w + w] = 1'b1;
      beat(2'b01, a, '0, "R4 R6 bit");
      check_state("R4 R6 single-bit inj");
    end
  endtask

  task automatic t_pull_b2b;
    logic [255:0] a, b;
    for (int n = 0; n < 16; n++) begin
      rand_blk(a); rand_blk(b);
      valid_i = 1'b1; mode_i = 2'b10; inj_i = a; stage_i = b;
      #0 check_state("R8 same-cycle pre-state");
      @(posedge clk_i);
      m = model_round(m, a, b);
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    check_state("R7 R8 pull b2b result");
  endtask

  task automatic t_hold;
    logic [255:0] a, b;
    rand_blk(a); rand_blk(b);
    inj_i = a; stage_i = b; mode_i = 2'b01; valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_state("R9 valid low hold");
    beat(2'b11, a, b, "R9 nop");
    check_state("R9 mode 11 hold");
  endtask

  task automatic t_clear;
    beat(2'b00, '1, '1, "R2 clear");
    check("R2 out_o cleared", out_o, '0);
    check("R2 fb_o cleared", fb_o, '0);
    t_zero_round();
  endtask

  initial begin
    t_reset();
    t_zero_round();
    t_push_seq();
    t_single_bit();
    t_pull_b2b();
    t_hold();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule